// File: doc/BRIEF.md
# Dual 8-bit / Joined 16-bit Timer with Handshaked Status Flags

The block holds two 8-bit up-counters, a low half and a high half, that advance on each clock where the count enable input is high. With the `mode16` input low they run as two separate 8-bit timers. With it high, the high half advances only when the low half wraps, so the pair forms one 16-bit timer. Each half has a writable 8-bit compare register. A combined control/status register holds four event flags: overflow and compare match for each half. It also holds two control bits per half: an overflow interrupt enable and a clear-on-match enable. The block drives one overflow interrupt line per half.

Software clears a flag in two steps. First it reads the status register while that flag is 1. Then it writes 0 to the flag's bit. Each of the four flags runs a small state machine with three states:

- `FL_IDLE`: the flag is 0.
- `FL_PEND`: the flag is 1 but has not yet been read as 1.
- `FL_ARMED`: the flag is 1 and has been read.

The transitions are:

- `FL_IDLE`→`FL_PEND` on a hardware set.
- `FL_PEND`→`FL_ARMED` on a status read.
- `FL_ARMED`→`FL_IDLE` on a 0-write.
- `FL_ARMED`→`FL_PEND` when a 0-write and a hardware set land in the same cycle.

All other combinations hold the state.

Top module: `cascade_timer`

## Requirements
- R1: After reset, the status register, both counters and both compare registers read 0x00, and both interrupt outputs are low.
- R2: The register map is selected by `addr`. Address 0 is control/status, with bit7 high overflow flag, bit6 high match flag, bit5 high overflow interrupt enable, bit4 high clear-on-match, bit3 low overflow flag, bit2 low match flag, bit1 low overflow interrupt enable and bit0 low clear-on-match. Address 1 is the low compare register (read/write). Address 2 is the high compare register (read/write). Address 3 is the low counter (read-only). Address 4 is the high counter (read-only). Any other address reads 0x00. Control bits read back as written.
- R3: Writing 1 to a flag bit never sets it, and writing to a counter address does not change the counter.
- R4: A 0-write clears a flag only if a status read returned 1 for that flag since it was last set. Otherwise the flag stays 1.
- R5: If a hardware set and a valid clear of the same flag fall in one cycle, the flag stays 1 and needs a fresh read before it can be cleared.
- R6: In split mode, each counter increases by one per enabled cycle and holds otherwise. Its overflow flag is set when it steps from 0xFF to 0x00.
- R7: A match flag is set on the counting step that brings the counter to its compare value.
- R8: In split mode, with a half's clear-on-match bit at 1, the next enabled cycle while that counter equals its compare value loads 0x00 into it and does not set its overflow flag.
- R9: In 16-bit mode, the high counter changes only when the low counter wraps. The low overflow flag is set on each low wrap. The high overflow flag is set on the step from 0xFFFF to 0x0000.
- R10: In 16-bit mode, the high match flag is set when both halves equal their compare values. The high clear-on-match bit then clears both counters on the next enabled cycle. The low clear-on-match bit does not affect counting.
- R11: Each interrupt output is high exactly when that half's overflow flag and overflow interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, one step per high cycle |
| mode16 | input | 1 | 1 joins the halves into one 16-bit counter |
| addr | input | 3 | Register select |
| rd_en | input | 1 | Read strobe; arms flags read as 1 |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_ovf_hi | output | 1 | High half overflow interrupt request |
| irq_ovf_lo | output | 1 | Low half overflow interrupt request |

## Verification
The hardest case to reach is a hardware set and an armed 0-write landing on the same edge. The bench first arms the low match flag with a read. It then runs the low counter through a full lap, stopping one step short of the compare value. Finally it raises the write strobe and the count enable in the same cycle. A follow-up unarmed 0-write shows that the flag survived and was disarmed. The 16-bit wrap of the high half is reached with one long enabled run of 65519 cycles.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_CMPL = 3'd1,
        A_CMPH = 3'd2,
        A_CNTL = 3'd3,
        A_CNTH = 3'd4
    } reg_addr_e;

    localparam int NFLAG     = 4;
    localparam int FI_OVF_LO = 0;
    localparam int FI_CMF_LO = 1;
    localparam int FI_OVF_HI = 2;
    localparam int FI_CMF_HI = 3;

    localparam int B_CCLR_LO = 0;
    localparam int B_OVIE_LO = 1;
    localparam int B_CCLR_HI = 4;
    localparam int B_OVIE_HI = 5;

    function automatic int flag_bit(input int k);
        return (k < 2) ? (3 - k) : (9 - k);
    endfunction

endpackage

// File: rtl/ctmr_flag.sv
module ctmr_flag
    import ctmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_req,
    input  logic rd_hit,
    output logic flag_q
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (set_ev) state_d = FL_PEND;
            end
            FL_PEND: begin
                if (rd_hit) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (clr_req && set_ev) state_d = FL_PEND;
                else if (clr_req)      state_d = FL_IDLE;
            end
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag_q = (state_q != FL_IDLE);
    end

endmodule

// File: rtl/ctmr_count.sv
module ctmr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         mode16,
    input  logic         cclr_lo,
    input  logic         cclr_hi,
    input  logic [W-1:0] cmp_lo,
    input  logic [W-1:0] cmp_hi,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         ovf_lo_ev,
    output logic         ovf_hi_ev,
    output logic         cmf_lo_ev,
    output logic         cmf_hi_ev
);

    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] nxt_lo;
    logic [W-1:0] nxt_hi;
    logic         wrap_lo;
    logic         wrap_hi;
    logic         hit_lo;
    logic         hit_hi;
    logic         eq_lo;
    logic         eq_hi;

    always_comb begin
        eq_lo   = (cnt_lo == cmp_lo);
        eq_hi   = (cnt_hi == cmp_hi);
        nxt_lo  = cnt_lo + 1'b1;
        nxt_hi  = cnt_hi;
        wrap_lo = 1'b0;
        wrap_hi = 1'b0;
        if (mode16) begin
            if (cclr_hi && eq_lo && eq_hi) begin
                nxt_lo = '0;
                nxt_hi = '0;
            end else begin
                wrap_lo = (cnt_lo == CMAX);
                nxt_hi  = wrap_lo ? cnt_hi + 1'b1 : cnt_hi;
                wrap_hi = wrap_lo && (cnt_hi == CMAX);
            end
            hit_hi = (nxt_lo == cmp_lo) && (nxt_hi == cmp_hi);
        end else begin
            if (cclr_lo && eq_lo) begin
                nxt_lo = '0;
            end else begin
                wrap_lo = (cnt_lo == CMAX);
            end
            if (cclr_hi && eq_hi) begin
                nxt_hi = '0;
            end else begin
                nxt_hi  = cnt_hi + 1'b1;
                wrap_hi = (cnt_hi == CMAX);
            end
            hit_hi = (nxt_hi == cmp_hi);
        end
        hit_lo = (nxt_lo == cmp_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (cnt_en) begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
        end
    end

    always_comb begin
        ovf_lo_ev = cnt_en && wrap_lo;
        ovf_hi_ev = cnt_en && wrap_hi;
        cmf_lo_ev = cnt_en && hit_lo;
        cmf_hi_ev = cnt_en && hit_hi;
    end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          mode16,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq_ovf_hi,
    output logic          irq_ovf_lo
);

    logic             cclr_lo;
    logic             cclr_hi;
    logic             ovie_lo;
    logic             ovie_hi;
    logic [W-1:0]     cmp_lo;
    logic [W-1:0]     cmp_hi;
    logic [W-1:0]     cnt_lo;
    logic [W-1:0]     cnt_hi;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] clr_req;
    logic [NFLAG-1:0] flag_q;
    logic             sel_stat;
    logic             stat_rd;
    logic [7:0]       stat;

    assign sel_stat = (addr == AW'(A_STAT));
    assign stat_rd  = rd_en && sel_stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cclr_lo <= 1'b0;
            cclr_hi <= 1'b0;
            ovie_lo <= 1'b0;
            ovie_hi <= 1'b0;
            cmp_lo  <= '0;
            cmp_hi  <= '0;
        end else if (wr_en) begin
            if (sel_stat) begin
                cclr_lo <= wdata[B_CCLR_LO];
                cclr_hi <= wdata[B_CCLR_HI];
                ovie_lo <= wdata[B_OVIE_LO];
                ovie_hi <= wdata[B_OVIE_HI];
            end
            if (addr == AW'(A_CMPL)) cmp_lo <= wdata;
            if (addr == AW'(A_CMPH)) cmp_hi <= wdata;
        end
    end

    ctmr_count #(.W(W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .mode16    (mode16),
        .cclr_lo   (cclr_lo),
        .cclr_hi   (cclr_hi),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .ovf_lo_ev (set_ev[FI_OVF_LO]),
        .ovf_hi_ev (set_ev[FI_OVF_HI]),
        .cmf_lo_ev (set_ev[FI_CMF_LO]),
        .cmf_hi_ev (set_ev[FI_CMF_HI])
    );

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        localparam int FB = flag_bit(k);
        assign clr_req[k] = wr_en && sel_stat && !wdata[FB];
        ctmr_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_ev  (set_ev[k]),
            .clr_req (clr_req[k]),
            .rd_hit  (stat_rd),
            .flag_q  (flag_q[k])
        );
    end

    always_comb begin
        stat = {flag_q[FI_OVF_HI], flag_q[FI_CMF_HI], ovie_hi, cclr_hi,
                flag_q[FI_OVF_LO], flag_q[FI_CMF_LO], ovie_lo, cclr_lo};
        case (addr)
            AW'(A_STAT): rdata = W'(stat);
            AW'(A_CMPL): rdata = cmp_lo;
            AW'(A_CMPH): rdata = cmp_hi;
            AW'(A_CNTL): rdata = cnt_lo;
            AW'(A_CNTH): rdata = cnt_hi;
            default:     rdata = '0;
        endcase
    end

    assign irq_ovf_hi = flag_q[FI_OVF_HI] && ovie_hi;
    assign irq_ovf_lo = flag_q[FI_OVF_LO] && ovie_lo;

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         mode16,
    input logic         cclr_lo,
    input logic         cclr_hi,
    input logic         ovie_lo,
    input logic         ovie_hi,
    input logic [W-1:0] cmp_lo,
    input logic [W-1:0] cmp_hi,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic [3:0]   set_ev,
    input logic [3:0]   clr_req,
    input logic [3:0]   flag_q,
    input logic         irq_ovf_hi,
    input logic         irq_ovf_lo
);

    // R3: a flag only rises after a hardware event
    a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(set_ev)) == 4'b0));

    // R4: a flag only falls after a 0-write to its bit
    a_r4_fall_has_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flag_q & $past(flag_q) & ~$past(clr_req)) == 4'b0));

    // R5: a hardware set always leaves the flag at 1
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_ev) & ~flag_q) == 4'b0));

    // R6: counters hold while counting is disabled
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R8: split-mode clear-on-match of the low counter
    a_r8_split_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16 && cnt_en && cclr_lo && cnt_lo == cmp_lo) |=> (cnt_lo == '0));

    // R9: in 16-bit mode the high half waits for a low wrap
    a_r9_hi_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && cnt_en && cnt_lo != {W{1'b1}} &&
         !(cclr_hi && cnt_lo == cmp_lo && cnt_hi == cmp_hi)) |=> $stable(cnt_hi));

    // R11: interrupts are blocked by a cleared enable
    a_r11_gate_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !ovie_hi |-> !irq_ovf_hi);
    a_r11_gate_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !ovie_lo |-> !irq_ovf_lo);

endmodule

bind cascade_timer ctmr_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .mode16     (mode16),
    .cclr_lo    (cclr_lo),
    .cclr_hi    (cclr_hi),
    .ovie_lo    (ovie_lo),
    .ovie_hi    (ovie_hi),
    .cmp_lo     (cmp_lo),
    .cmp_hi     (cmp_hi),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .set_ev     (set_ev),
    .clr_req    (clr_req),
    .flag_q     (flag_q),
    .irq_ovf_hi (irq_ovf_hi),
    .irq_ovf_lo (irq_ovf_lo)
);

// File: tb/cascade_timer_test.sv
module cascade_timer_test;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;
    localparam int NV = 43;

    // {op, addr, data, expected, requirement number}
    localparam logic [24:0] VEC [0:NV-1] = '{
        {OP_RD, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 status
        {OP_RD, 3'd3, 8'h00, 8'h00, 4'd1},   // R1 low counter
        {OP_RD, 3'd4, 8'h00, 8'h00, 4'd1},   // R1 high counter
        {OP_IQ, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 interrupts
        {OP_WR, 3'd1, 8'h05, 8'h00, 4'd2},
        {OP_WR, 3'd2, 8'h03, 8'h00, 4'd2},
        {OP_RD, 3'd1, 8'h00, 8'h05, 4'd2},   // R2 low compare
        {OP_RD, 3'd2, 8'h00, 8'h03, 4'd2},   // R2 high compare
        {OP_RD, 3'd5, 8'h00, 8'h00, 4'd2},   // R2 unused address
        {OP_WR, 3'd0, 8'hCC, 8'h00, 4'd3},
        {OP_RD, 3'd0, 8'h00, 8'h00, 4'd3},   // R3 writing 1 sets nothing
        {OP_WR, 3'd3, 8'h55, 8'h00, 4'd3},
        {OP_RD, 3'd3, 8'h00, 8'h00, 4'd3},   // R3 counter not writable
        {OP_TK, 3'd0, 8'd3,  8'h00, 4'd6},
        {OP_RD, 3'd3, 8'h00, 8'h03, 4'd6},   // R6 three steps
        {OP_RD, 3'd0, 8'h00, 8'h40, 4'd7},   // R7 high match at 3
        {OP_TK, 3'd0, 8'd2,  8'h00, 4'd7},
        {OP_RD, 3'd0, 8'h00, 8'h44, 4'd7},   // R7 low match at 5
        {OP_WR, 3'd0, 8'h00, 8'h00, 4'd4},
        {OP_RD, 3'd0, 8'h00, 8'h00, 4'd4},   // R4 armed clear
        {OP_WR, 3'd1, 8'h06, 8'h00, 4'd4},
        {OP_TK, 3'd0, 8'd1,  8'h00, 4'd4},
        {OP_WR, 3'd0, 8'h00, 8'h00, 4'd4},
        {OP_RD, 3'd0, 8'h00, 8'h04, 4'd4},   // R4 unarmed clear ignored
        {OP_WR, 3'd0, 8'h00, 8'h00, 4'd4},
        {OP_RD, 3'd0, 8'h00, 8'h00, 4'd4},   // R4 cleared once armed
        {OP_WR, 3'd0, 8'h01, 8'h00, 4'd8},
        {OP_TK, 3'd0, 8'd1,  8'h00, 4'd8},
        {OP_RD, 3'd3, 8'h00, 8'h00, 4'd8},   // R8 low cleared on match
        {OP_RD, 3'd0, 8'h00, 8'h01, 4'd8},   // R8 no overflow, R2 readback
        {OP_TK, 3'd0, 8'd6,  8'h00, 4'd7},
        {OP_RD, 3'd0, 8'h00, 8'h05, 4'd7},   // R7 match again from 0
        {OP_WR, 3'd0, 8'h01, 8'h00, 4'd4},
        {OP_RD, 3'd0, 8'h00, 8'h01, 4'd4},   // R4 control kept, flag gone
        {OP_WR, 3'd0, 8'h02, 8'h00, 4'd6},
        {OP_TK, 3'd0, 8'd250, 8'h00, 4'd6},
        {OP_RD, 3'd0, 8'h00, 8'hCA, 4'd6},   // R6 both halves overflowed
        {OP_RD, 3'd3, 8'h00, 8'h00, 4'd6},   // R6 low wrapped to 0
        {OP_RD, 3'd4, 8'h00, 8'h07, 4'd6},   // R6 high 13+250 mod 256
        {OP_IQ, 3'd0, 8'h00, 8'h01, 4'd11},  // R11 low irq enabled
        {OP_WR, 3'd0, 8'h00, 8'h00, 4'd11},
        {OP_IQ, 3'd0, 8'h00, 8'h00, 4'd11},  // R11 irq dropped
        {OP_RD, 3'd0, 8'h00, 8'h00, 4'd4}    // R4 all armed flags cleared
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       mode16 = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_ovf_hi;
    logic       irq_ovf_lo;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cascade_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .mode16     (mode16),
        .addr       (addr),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .irq_ovf_hi (irq_ovf_hi),
        .irq_ovf_lo (irq_ovf_lo)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] mask,
                      input logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        #1 check(tag, rdata & mask, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic irq(input string tag, input logic [1:0] exp);
        #1 check(tag, {6'b0, irq_ovf_hi, irq_ovf_lo}, {6'b0, exp});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [2:0] va;
            logic [7:0] vd;
            logic [7:0] ve;
            string      tg;
            op = VEC[i][24:23];
            va = VEC[i][22:20];
            vd = VEC[i][19:12];
            ve = VEC[i][11:4];
            tg = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            case (op)
                OP_WR: wr(va, vd);
                OP_RD: rd(tg, va, 8'hFF, ve);
                OP_TK: tick(int'(vd));
                default: irq(tg, ve[1:0]);
            endcase
        end

        // R5: set and armed clear in the same cycle; low is 0, compare 6
        tick(6);
        rd("R5 match seen", 3'd0, 8'h04, 8'h04);
        tick(255);
        rd("R5 low one short", 3'd3, 8'hFF, 8'h05);
        addr = 3'd0; wdata = 8'h00; wr_en = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        wr(3'd0, 8'h00);
        rd("R5 set wins and disarms", 3'd0, 8'h04, 8'h04);
        wr(3'd0, 8'h00);
        rd("R5 cleared after new read", 3'd0, 8'h04, 8'h00);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        mode16 = 1'b1;
        @(negedge clk);
        rd("R1 status after reset", 3'd0, 8'hFF, 8'h00);
        rd("R1 compare after reset", 3'd1, 8'hFF, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 high counter after reset", 3'd4, 8'hFF, 8'h00);

        // R9 / R10: joined mode, compare 0x0110
        wr(3'd1, 8'h10);
        wr(3'd2, 8'h01);
        tick(255);
        rd("R9 high waits", 3'd4, 8'hFF, 8'h00);
        rd("R9 no overflow yet", 3'd0, 8'h88, 8'h00);
        tick(1);
        rd("R9 high carries", 3'd4, 8'hFF, 8'h01);
        rd("R9 low wrapped", 3'd3, 8'hFF, 8'h00);
        rd("R9 low overflow only", 3'd0, 8'h88, 8'h08);
        tick(16);
        rd("R10 16-bit match", 3'd0, 8'h40, 8'h40);
        wr(3'd0, 8'h11);
        tick(1);
        rd("R10 low cleared", 3'd3, 8'hFF, 8'h00);
        rd("R10 high cleared", 3'd4, 8'hFF, 8'h00);
        rd("R10 clear sets no overflow", 3'd0, 8'h88, 8'h00);
        tick(17);
        rd("R10 low clear bit ignored", 3'd3, 8'hFF, 8'h11);
        wr(3'd0, 8'h20);
        tick(65519);
        irq("R11 high irq from 16-bit wrap", 2'b10);
        wr(3'd0, 8'h00);
        irq("R11 high irq blocked", 2'b00);
        rd("R9 high overflow held unarmed", 3'd0, 8'h80, 8'h80);
        rd("R9 full wrap to zero", 3'd4, 8'hFF, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule